// File: doc/BRIEF.md
# Flash Command Sequencer

This block turns a stream of bus write cycles into flash operations, in the manner of a NOR flash command user interface. Each write carries an address and a data word; the low byte of the data word is the command code. One-cycle codes change what a bus read returns (array, status byte, identifier area or query area) or clear the sticky status bits. Multi-cycle codes collect an address and data, check the confirm code, and then issue a one-cycle start pulse with the operation kind, address and data to an external program/erase engine.

While that engine runs, the sequencer forces reads to the status byte and accepts only a suspend request. A suspended operation can be resumed later. While it is suspended a small set of commands is accepted. That set is larger after an erase suspend, when a program or a lock command may run inside it. The engine reports the end of an operation with a done pulse, which carries a failure flag and a lock-refusal flag. The sequencer keeps these results in its status byte.

Top module: `flash_cmd_ui`

## Requirements
- R1: After reset the read select is array (0) and the status byte is 80h. No start, suspend or resume pulse is issued. Status bits: 7 ready, 6 erase suspended, 5 erase error, 4 program error, 2 program suspended, 1 lock refusal; bits 3 and 0 read 0.
- R2: In the ready state, code FFh selects array (0), 70h status (1), 90h identifier (2) and 98h query (3). Any unrecognised code selects array.
- R3: 20h followed by D0h issues a start with kind 2 (erase) and the second cycle's address. Any other second cycle issues no start, sets status bits 5 and 4, and selects status.
- R4: 40h or 10h followed by an address/data cycle issues a start of kind 0 (program) with that address and data. C0h followed by a cycle issues kind 3 (protection program).
- R5: 30h then two cycles whose addresses differ in bit 0 alone issues a start of kind 1. It carries the first address and both data words. If the addresses differ in any other way, no start is issued and status bit 4 is set.
- R6: 60h followed by 01h, D0h or 2Fh issues a start of kind 4 (lock), 5 (unlock) or 6 (lock-down) with the second cycle's address. Any other second cycle issues no start and selects array.
- R7: While an operation of kind 0 to 3 runs, status bit 7 is 0 and reads select status. Writes other than B0h have no effect. A done pulse returns status bit 7 to 1.
- R8: A done pulse with failure sets bit 5 after an erase and bit 4 after any other kind. If lock refusal is flagged as well, bit 1 is also set. These bits survive the start of a new operation.
- R9: 50h in the ready state clears status bits 5, 4, 3 and 1.
- R10: B0h during a program, double-word program or erase issues a suspend pulse and sets bit 2 (program) or bit 6 (erase), with bit 7 at 1. B0h during a protection program is ignored.
- R11: While suspended, FFh, 70h, 90h and 98h select the read source. D0h issues a resume pulse, clears the suspend bit and returns to busy. After a program suspend, other codes start nothing and select array.
- R12: During an erase suspend, program and lock sequences are accepted. When a program started there completes, the sequencer returns to the erase-suspended state with bit 6 still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, aborts any operation |
| wr_i | input | 1 | Bus write strobe, one cycle per write |
| addr_i | input | ADDR_W | Write address |
| data_i | input | DATA_W | Write data; low byte is the command code |
| ctl_done_i | input | 1 | Engine finished the running operation (pulse) |
| ctl_fail_i | input | 1 | With done: operation failed |
| ctl_lock_i | input | 1 | With done: failure caused by a locked block |
| rd_sel_o | output | 2 | Read source: 0 array, 1 status, 2 identifier, 3 query |
| op_start_o | output | 1 | Start pulse to the engine |
| op_code_o | output | 3 | Operation kind for the start pulse |
| op_addr_o | output | ADDR_W | Operation address |
| op_data_o | output | DATA_W | Operation data (first word) |
| op_data2_o | output | DATA_W | Second word of a double-word program |
| op_suspend_o | output | 1 | Suspend pulse to the engine |
| op_resume_o | output | 1 | Resume pulse to the engine |
| status_o | output | 8 | Status byte |

## Verification
Directed sequences cover every command code, both the correct and the wrong confirm cycle of each multi-cycle command, and paired addresses that differ in bit 0 against pairs that differ elsewhere. These show that each sequence starts only on a valid second cycle. Suspend is tried during a program, an erase and a protection program, and it is followed by allowed and refused commands. This separates the two suspend subsets and the nested-program return. Constrained-random rounds mix operation kinds with random failure and lock-refusal outcomes and random read-mode codes. Each round is checked against a status value computed in the bench, which tells erase errors from program errors and shows whether bit 1 is set only together with them.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {RD_ARRAY = 2'd0, RD_STATUS = 2'd1, RD_IDENT = 2'd2, RD_QUERY = 2'd3} rd_mode_e;
  typedef enum logic [2:0] {
    OP_PROG = 3'd0, OP_DWPROG = 3'd1, OP_ERASE = 3'd2, OP_OTP = 3'd3,
    OP_LOCK = 3'd4, OP_UNLOCK = 3'd5, OP_LOCKDN = 3'd6
  } op_e;
  typedef enum logic [2:0] {
    S_IDLE, S_ERS, S_PRG, S_DW1, S_DW2, S_LCK, S_BUSY, S_SUSP
  } seq_st_e;

  localparam int unsigned CMD_W = 8;
  localparam logic [CMD_W-1:0] C_ARRAY  = 8'hFF;
  localparam logic [CMD_W-1:0] C_STATUS = 8'h70;
  localparam logic [CMD_W-1:0] C_IDENT  = 8'h90;
  localparam logic [CMD_W-1:0] C_QUERY  = 8'h98;
  localparam logic [CMD_W-1:0] C_CLEAR  = 8'h50;
  localparam logic [CMD_W-1:0] C_SUSP   = 8'hB0;
  localparam logic [CMD_W-1:0] C_CONF   = 8'hD0;
  localparam logic [CMD_W-1:0] C_ERASE  = 8'h20;
  localparam logic [CMD_W-1:0] C_PROG_A = 8'h40;
  localparam logic [CMD_W-1:0] C_PROG_B = 8'h10;
  localparam logic [CMD_W-1:0] C_OTP    = 8'hC0;
  localparam logic [CMD_W-1:0] C_DWPROG = 8'h30;
  localparam logic [CMD_W-1:0] C_LKSET  = 8'h60;
  localparam logic [CMD_W-1:0] C_LKON   = 8'h01;
  localparam logic [CMD_W-1:0] C_LKDN   = 8'h2F;
endpackage

// File: rtl/fcu_status.sv
module fcu_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       set_perr_i,
  input  logic       set_eerr_i,
  input  logic       set_lerr_i,
  input  logic       ready_i,
  input  logic       esus_i,
  input  logic       psus_i,
  output logic [7:0] status_o
);
  logic eerr_q, perr_q, verr_q, lerr_q;

  // Clear has priority; sticky otherwise. Bit 3 has no setter here.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eerr_q <= 1'b0;
      perr_q <= 1'b0;
      verr_q <= 1'b0;
      lerr_q <= 1'b0;
    end else if (clr_i) begin
      eerr_q <= 1'b0;
      perr_q <= 1'b0;
      verr_q <= 1'b0;
      lerr_q <= 1'b0;
    end else begin
      eerr_q <= eerr_q | set_eerr_i;
      perr_q <= perr_q | set_perr_i;
      lerr_q <= lerr_q | set_lerr_i;
    end
  end

  assign status_o = {ready_i, esus_i, eerr_q, perr_q, verr_q, psus_i, lerr_q, 1'b0};

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (status_o[5:3] == 3'b000 && status_o[1] == 1'b0));
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[4] && !clr_i) |=> status_o[4]);
  p_lock_needs_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_lerr_i |-> (set_perr_i || set_eerr_i));
endmodule

// File: rtl/fcu_seq.sv
module fcu_seq
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              done_i,
  input  logic              fail_i,
  input  logic              lockerr_i,
  output rd_mode_e          rd_sel_o,
  output logic              start_o,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] data2_o,
  output logic              susp_o,
  output logic              resume_o,
  output logic              busy_o,
  output logic              esus_o,
  output logic              psus_o,
  output logic              clr_o,
  output logic              set_perr_o,
  output logic              set_eerr_o,
  output logic              set_lerr_o
);
  localparam logic [ADDR_W-1:0] PAIR_BIT = ADDR_W'(1);

  seq_st_e st_q, st_d;
  rd_mode_e mode_q, mode_d;
  op_e cur_q, cur_d, opk_d;
  logic esus_d, psus_d, start_d, susp_d, res_d;
  logic [ADDR_W-1:0] a1_q, a1_d, addr_d;
  logic [DATA_W-1:0] d1_q, d1_d, data_d, data2_d;
  logic [CMD_W-1:0] cmd;
  seq_st_e back;

  assign cmd  = data_i[CMD_W-1:0];
  assign back = esus_o ? S_SUSP : S_IDLE;

  always_comb begin
    st_d = st_q; mode_d = mode_q; cur_d = cur_q;
    esus_d = esus_o; psus_d = psus_o;
    a1_d = a1_q; d1_d = d1_q;
    start_d = 1'b0; susp_d = 1'b0; res_d = 1'b0;
    opk_d = op_o; addr_d = addr_o; data_d = data_o; data2_d = data2_o;
    clr_o = 1'b0; set_perr_o = 1'b0; set_eerr_o = 1'b0; set_lerr_o = 1'b0;
    unique case (st_q)
      S_IDLE: if (wr_i) begin
        unique case (cmd)
          C_ARRAY:  mode_d = RD_ARRAY;
          C_STATUS: mode_d = RD_STATUS;
          C_IDENT:  mode_d = RD_IDENT;
          C_QUERY:  mode_d = RD_QUERY;
          C_CLEAR:  clr_o = 1'b1;
          C_ERASE:  st_d = S_ERS;
          C_PROG_A, C_PROG_B: begin st_d = S_PRG; cur_d = OP_PROG; end
          C_OTP:    begin st_d = S_PRG; cur_d = OP_OTP; end
          C_DWPROG: st_d = S_DW1;
          C_LKSET:  st_d = S_LCK;
          default:  mode_d = RD_ARRAY;
        endcase
      end
      S_ERS: if (wr_i) begin
        mode_d = RD_STATUS;
        if (cmd == C_CONF) begin
          start_d = 1'b1; opk_d = OP_ERASE; cur_d = OP_ERASE; addr_d = addr_i; st_d = S_BUSY;
        end else begin
          set_eerr_o = 1'b1; set_perr_o = 1'b1; st_d = S_IDLE;
        end
      end
      S_PRG: if (wr_i) begin
        start_d = 1'b1; opk_d = cur_q; addr_d = addr_i; data_d = data_i;
        mode_d = RD_STATUS; st_d = S_BUSY;
      end
      S_DW1: if (wr_i) begin
        a1_d = addr_i; d1_d = data_i; st_d = S_DW2;
      end
      S_DW2: if (wr_i) begin
        mode_d = RD_STATUS;
        if (addr_i == (a1_q ^ PAIR_BIT)) begin
          start_d = 1'b1; opk_d = OP_DWPROG; cur_d = OP_DWPROG;
          addr_d = a1_q; data_d = d1_q; data2_d = data_i; st_d = S_BUSY;
        end else begin
          set_perr_o = 1'b1; st_d = S_IDLE;
        end
      end
      S_LCK: if (wr_i) begin
        st_d = back; mode_d = RD_STATUS; addr_d = addr_i;
        unique case (cmd)
          C_LKON:  begin start_d = 1'b1; opk_d = OP_LOCK;   end
          C_CONF:  begin start_d = 1'b1; opk_d = OP_UNLOCK; end
          C_LKDN:  begin start_d = 1'b1; opk_d = OP_LOCKDN; end
          default: mode_d = RD_ARRAY;
        endcase
      end
      S_BUSY: begin
        if (done_i) begin
          st_d = back;
          if (fail_i) begin
            if (cur_q == OP_ERASE) set_eerr_o = 1'b1;
            else set_perr_o = 1'b1;
            set_lerr_o = lockerr_i;
          end
        end else if (wr_i && cmd == C_SUSP && !esus_o && cur_q != OP_OTP) begin
          susp_d = 1'b1; st_d = S_SUSP;
          if (cur_q == OP_ERASE) esus_d = 1'b1;
          else psus_d = 1'b1;
        end
      end
      S_SUSP: if (wr_i) begin
        unique case (cmd)
          C_ARRAY:  mode_d = RD_ARRAY;
          C_STATUS: mode_d = RD_STATUS;
          C_IDENT:  mode_d = RD_IDENT;
          C_QUERY:  mode_d = RD_QUERY;
          C_CONF: begin
            res_d = 1'b1; st_d = S_BUSY; mode_d = RD_STATUS;
            if (esus_o) cur_d = OP_ERASE;
            esus_d = 1'b0; psus_d = 1'b0;
          end
          C_PROG_A, C_PROG_B:
            if (esus_o) begin st_d = S_PRG; cur_d = OP_PROG; end
            else mode_d = RD_ARRAY;
          C_LKSET:
            if (esus_o) st_d = S_LCK;
            else mode_d = RD_ARRAY;
          default: mode_d = RD_ARRAY;
        endcase
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; mode_q <= RD_ARRAY; cur_q <= OP_PROG;
      esus_o <= 1'b0; psus_o <= 1'b0;
      a1_q <= '0; d1_q <= '0;
      start_o <= 1'b0; susp_o <= 1'b0; resume_o <= 1'b0;
      op_o <= OP_PROG; addr_o <= '0; data_o <= '0; data2_o <= '0;
    end else begin
      st_q <= st_d; mode_q <= mode_d; cur_q <= cur_d;
      esus_o <= esus_d; psus_o <= psus_d;
      a1_q <= a1_d; d1_q <= d1_d;
      start_o <= start_d; susp_o <= susp_d; resume_o <= res_d;
      op_o <= opk_d; addr_o <= addr_d; data_o <= data_d; data2_o <= data2_d;
    end
  end

  assign busy_o   = (st_q == S_BUSY);
  assign rd_sel_o = (st_q == S_IDLE || st_q == S_SUSP) ? mode_q : RD_STATUS;

  p_susp_from_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_o |-> (busy_o == 1'b0 && (esus_o || psus_o)));
  p_otp_no_susp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cur_q == OP_OTP) |=> !susp_o);
  p_susp_flags_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(esus_o && psus_o));
  p_start_resume_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_o && resume_o));
  p_resume_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> (busy_o && !esus_o && !psus_o));
endmodule

// File: rtl/flash_cmd_ui.sv
module flash_cmd_ui
  import flash_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ctl_done_i,
  input  logic              ctl_fail_i,
  input  logic              ctl_lock_i,
  output logic [1:0]        rd_sel_o,
  output logic              op_start_o,
  output logic [2:0]        op_code_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic [DATA_W-1:0] op_data2_o,
  output logic              op_suspend_o,
  output logic              op_resume_o,
  output logic [7:0]        status_o
);
  rd_mode_e rd_sel;
  op_e      op_kind;
  logic busy, esus, psus, clr, set_perr, set_eerr, set_lerr;

  fcu_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni, .wr_i, .addr_i, .data_i,
    .done_i(ctl_done_i), .fail_i(ctl_fail_i), .lockerr_i(ctl_lock_i),
    .rd_sel_o(rd_sel), .start_o(op_start_o), .op_o(op_kind),
    .addr_o(op_addr_o), .data_o(op_data_o), .data2_o(op_data2_o),
    .susp_o(op_suspend_o), .resume_o(op_resume_o),
    .busy_o(busy), .esus_o(esus), .psus_o(psus),
    .clr_o(clr), .set_perr_o(set_perr), .set_eerr_o(set_eerr), .set_lerr_o(set_lerr)
  );

  fcu_status u_status (
    .clk_i, .rst_ni, .clr_i(clr),
    .set_perr_i(set_perr), .set_eerr_i(set_eerr), .set_lerr_i(set_lerr),
    .ready_i(!busy), .esus_i(esus), .psus_i(psus), .status_o
  );

  assign rd_sel_o  = rd_sel;
  assign op_code_o = op_kind;

  p_busy_reads_status_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_o[7] |-> (rd_sel_o == 2'd1));
  p_start_kind_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_o |-> (op_code_o != 3'd7));
endmodule

// File: tb/flash_cmd_ui_tb.sv
module flash_cmd_ui_tb;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam int DELAY = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic done_r, fail_r = 1'b0, lock_r = 1'b0;
  logic [1:0] rd_sel;
  logic op_start, op_susp, op_res;
  logic [2:0] op_code;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data, op_data2;
  logic [7:0] status;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  flash_cmd_ui #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr_i), .addr_i(addr_i), .data_i(data_i),
    .ctl_done_i(done_r), .ctl_fail_i(fail_r), .ctl_lock_i(lock_r),
    .rd_sel_o(rd_sel), .op_start_o(op_start), .op_code_o(op_code),
    .op_addr_o(op_addr), .op_data_o(op_data), .op_data2_o(op_data2),
    .op_suspend_o(op_susp), .op_resume_o(op_res), .status_o(status)
  );

  // Stub engine: fixed delay, pausable, one saved context for a nested program.
  int cnt, saved;
  logic run;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= 0; saved <= 0; run <= 1'b0; done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (op_start && op_code <= 3'd3) begin cnt <= DELAY; run <= 1'b1; end
      else if (op_susp) begin saved <= cnt; run <= 1'b0; end
      else if (op_res) begin cnt <= saved; run <= 1'b1; end
      else if (run) begin
        if (cnt == 0) begin run <= 1'b0; done_r <= 1'b1; end
        else cnt <= cnt - 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_i = 1'b1; addr_i = a; data_i = d;
    @(negedge clk); wr_i = 1'b0;
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (!status[7] && n < 500) begin @(negedge clk); n++; end
    chk({req, " ready"}, int'(status[7]), 1);
  endtask

  function automatic logic [7:0] exp_status(input int kind, input bit f, input bit l);
    logic [7:0] s = 8'h80;
    if (f) s |= (kind == 2) ? 8'h20 : 8'h10;
    if (f && l) s |= 8'h02;
    return s;
  endfunction

  function automatic int exp_mode(input logic [7:0] c);
    case (c)
      8'h70: return 1;
      8'h90: return 2;
      8'h98: return 3;
      default: return 0;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_sel", rd_sel, 0);
    chk("R1 status", status, 8'h80);
    chk("R1 pulses", {op_start, op_susp, op_res}, 0);

    // R2 read modes
    wr(0, 16'h0070); chk("R2 status mode", rd_sel, 1);
    wr(0, 16'h0090); chk("R2 ident mode", rd_sel, 2);
    wr(0, 16'h0098); chk("R2 query mode", rd_sel, 3);
    wr(0, 16'h00FF); chk("R2 array mode", rd_sel, 0);
    wr(0, 16'h0090); wr(0, 16'h0077); chk("R2 unknown code", rd_sel, 0);

    // R4 program, R7 busy behaviour
    wr(0, 16'h0040); wr(21'h1234, 16'hBEEF);
    chk("R4 start", op_start, 1); chk("R4 kind", op_code, 0);
    chk("R4 addr", op_addr, 21'h1234); chk("R4 data", op_data, 16'hBEEF);
    chk("R7 busy status", status, 8'h00); chk("R7 busy sel", rd_sel, 1);
    wr(0, 16'h0090); chk("R7 ignored write", rd_sel, 1);
    wait_ready("R7"); chk("R7 done status", status, 8'h80);
    wr(0, 16'h0010); wr(21'h55, 16'h1111); chk("R4 alt kind", op_code, 0);
    wait_ready("R4");
    wr(0, 16'h00C0); wr(21'h81, 16'h2222);
    chk("R4 otp start", op_start, 1); chk("R4 otp kind", op_code, 3);
    // R10 suspend refused for protection program
    wr(0, 16'h00B0); chk("R10 otp no suspend", op_susp, 0); chk("R10 otp busy", status, 8'h00);
    wait_ready("R10");

    // R3 erase
    wr(0, 16'h0020); wr(21'h18000, 16'h00D0);
    chk("R3 start", op_start, 1); chk("R3 kind", op_code, 2); chk("R3 addr", op_addr, 21'h18000);
    wait_ready("R3");
    wr(0, 16'h0020); wr(21'h18000, 16'h0055);
    chk("R3 bad confirm start", op_start, 0); chk("R3 bad confirm status", status, 8'hB0);
    chk("R3 sel", rd_sel, 1);
    wr(0, 16'h0050); chk("R9 clear", status, 8'h80);

    // R5 double word
    wr(0, 16'h0030); wr(21'h100, 16'hA1A1); wr(21'h101, 16'hB2B2);
    chk("R5 start", op_start, 1); chk("R5 kind", op_code, 1); chk("R5 addr", op_addr, 21'h100);
    chk("R5 data", op_data, 16'hA1A1); chk("R5 data2", op_data2, 16'hB2B2);
    wait_ready("R5");
    wr(0, 16'h0030); wr(21'h100, 16'h1); wr(21'h103, 16'h2);
    chk("R5 bad pair start", op_start, 0); chk("R5 bad pair status", status, 8'h90);
    wr(0, 16'h0050); chk("R9 clear after pair", status, 8'h80);

    // R6 lock commands
    wr(0, 16'h0060); wr(21'h40000, 16'h0001); chk("R6 lock", {op_start, op_code}, 4'hC);
    chk("R6 lock addr", op_addr, 21'h40000);
    wr(0, 16'h0060); wr(21'h40000, 16'h00D0); chk("R6 unlock", {op_start, op_code}, 4'hD);
    wr(0, 16'h0060); wr(21'h40000, 16'h002F); chk("R6 lockdown", {op_start, op_code}, 4'hE);
    wr(0, 16'h0060); wr(21'h40000, 16'h0077); chk("R6 bad", op_start, 0); chk("R6 bad sel", rd_sel, 0);

    // R8 failure with lock refusal, sticky across new start
    fail_r = 1'b1; lock_r = 1'b1;
    wr(0, 16'h0040); wr(21'h7, 16'h7);
    wait_ready("R8"); chk("R8 fail lock", status, 8'h92);
    fail_r = 1'b0; lock_r = 1'b0;
    wr(0, 16'h0040); wr(21'h8, 16'h8); chk("R8 sticky busy", status, 8'h12);
    wait_ready("R8b"); chk("R8 sticky done", status, 8'h92);
    wr(0, 16'h0050); chk("R9 clear bits", status, 8'h80);

    // R10/R11 program suspend
    wr(0, 16'h0040); wr(21'h10, 16'h1234);
    wr(0, 16'h00B0); chk("R10 suspend pulse", op_susp, 1); chk("R10 psus status", status, 8'h84);
    wr(0, 16'h0090); chk("R11 ident in suspend", rd_sel, 2);
    wr(0, 16'h0020); chk("R11 refused start", op_start, 0); chk("R11 refused sel", rd_sel, 0);
    chk("R11 still suspended", status, 8'h84);
    wr(0, 16'h00D0); chk("R11 resume pulse", op_res, 1); chk("R11 resumed", status, 8'h00);
    wait_ready("R11"); chk("R11 done", status, 8'h80);

    // R12 erase suspend with nested program and lock
    wr(0, 16'h0020); wr(21'h8000, 16'h00D0);
    wr(0, 16'h00B0); chk("R10 esus status", status, 8'hC0);
    wr(0, 16'h0040); wr(21'h20, 16'h55AA);
    chk("R12 nested start", {op_start, op_code}, 4'h8); chk("R12 nested busy", status, 8'h40);
    wait_ready("R12"); chk("R12 back to esus", status, 8'hC0);
    wr(0, 16'h0060); wr(21'h9000, 16'h0001);
    chk("R12 lock in esus", {op_start, op_code}, 4'hC); chk("R12 esus kept", status, 8'hC0);
    wr(0, 16'h00D0); chk("R11 erase resume", status, 8'h00);
    wait_ready("R12b"); chk("R12 final", status, 8'h80);

    // Random rounds
    for (int it = 0; it < 40; it++) begin
      int kind = $urandom % 3;
      bit f = 1'($urandom % 2);
      bit l = 1'($urandom % 2);
      logic [AW-1:0] a = AW'($urandom) & ~AW'(1);
      logic [7:0] mc;
      wr(0, 16'h0050); chk("R9 random clear", status, 8'h80);
      fail_r = f; lock_r = l;
      if (kind == 0) begin wr(0, 16'h0040); wr(a, 16'($urandom)); end
      else if (kind == 1) begin wr(0, 16'h0030); wr(a, 16'h1); wr(a | AW'(1), 16'h2); end
      else begin wr(0, 16'h0020); wr(a, 16'h00D0); end
      chk("R4 random kind", op_code, kind);
      wait_ready("R8 random");
      chk("R8 random status", status, exp_status(kind, f, l));
      fail_r = 1'b0; lock_r = 1'b0;
      case ($urandom % 5)
        0: mc = 8'hFF; 1: mc = 8'h70; 2: mc = 8'h90; 3: mc = 8'h98; default: mc = 8'h3C;
      endcase
      wr(0, {8'h00, mc}); chk("R2 random mode", rd_sel, exp_mode(mc));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule